// File: doc/BRIEF.md
# E1 Receive Channel Signaling Extractor

The block sits on the receive side of an E1 link, after frame and multiframe alignment. Each cycle it may accept one timeslot byte. The byte carries a timeslot number (0 to 31) and its frame number (0 to 15) within the signaling multiframe.

When channel-associated signaling is enabled, the block takes the signaling byte in timeslot 16 and splits it into two ABCD nibbles. It stores each nibble in the register of the voice channel that the frame number selects. A host reads these registers through a plain address/data port.

The same port also sets two controls for each timeslot. Both act on the byte stream, which leaves the block one cycle later:
- alternate-bit inversion flips every second bit of the byte;
- freeze holds the last output value of that timeslot.

Top module: `e1_cas_rx`

## Requirements
- R1: After reset, out_valid_o is 0, every signaling register reads 0 and every timeslot control register reads 0.
- R2: For a timeslot-16 byte in frame f (1 to 15), bits 7:4 of the byte are stored at offset 0x70+f, which is channel f. Bits 3:0 of the byte are stored at offset 0x80+f, which is channel 15+f. Within each nibble, A is bit 3 and D is bit 0.
- R3: Signaling registers update only while sig_mode_i is 0. With sig_mode_i at 1 they keep their contents.
- R4: Bytes in frame 0, and bytes in any timeslot other than 16, never change a signaling register.
- R5: The read data for the address on reg_addr_i appears on reg_rdata_o one cycle later. Signaling reads return the nibble in bits 3:0 and 0 in bits 15:4. Offset 0x80 and unmapped offsets read 0.
- R6: Host writes to offsets 0x71 to 0x8F have no effect on the stored nibbles.
- R7: The control register for timeslot t sits at offset 0x90+t. Bit 9 is alternate-bit inversion and bit 8 is freeze. All other bits read 0.
- R8: Every accepted byte appears on out_data_o one cycle later, with out_valid_o high and its timeslot number on out_ts_o. With both controls clear, the byte passes unchanged.
- R9: With inversion set for a timeslot, its output byte is the input XOR 0x55. That flips bit positions 2, 4, 6 and 8, counted from position 1 at the MSB.
- R10: With freeze set for a timeslot, its output repeats the last value it produced for that timeslot and ignores new data. Other timeslots are unaffected, and clearing freeze resumes normal output.
- R11: A control write takes effect for bytes accepted after the write cycle. A read of a signaling register in the same cycle as its update returns the old nibble; the next read returns the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Timeslot byte present |
| in_data_i | input | 8 | Timeslot byte, bit 7 is first on the line |
| in_ts_i | input | 5 | Timeslot number |
| in_frame_i | input | 4 | Frame number within the multiframe |
| sig_mode_i | input | 1 | 0 enables channel signaling capture |
| reg_addr_i | input | 8 | Host register offset |
| reg_we_i | input | 1 | Host write strobe |
| reg_wdata_i | input | 16 | Host write data |
| reg_rdata_o | output | 16 | Host read data, one cycle after address |
| out_valid_o | output | 1 | Output byte present |
| out_data_o | output | 8 | Processed timeslot byte |
| out_ts_o | output | 5 | Timeslot number of output byte |

## Verification
The host port and the receive stream are independent, so two kinds of collision can happen in one cycle.

First, a control write can arrive with a byte of the very timeslot it targets. The bench drives both in the same cycle. The byte must leave with the old setting, and the next byte of that timeslot must show the new one.

Second, a host read can address the signaling register that a timeslot-16 byte updates in that same cycle. The bench presents both together. The read must return the old nibble, and a repeat read must return the new one.

// File: rtl/e1_cas_pkg.sv
package e1_cas_pkg;
  localparam int unsigned NUM_TS    = 32;
  localparam int unsigned TS_W      = $clog2(NUM_TS);
  localparam int unsigned NUM_FRM   = 16;
  localparam int unsigned FRM_W     = $clog2(NUM_FRM);
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned NIB_W     = 4;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned SIG_TS    = 16;
  localparam logic [ADDR_W-1:0] SIG_BASE = 8'h70;
  localparam logic [ADDR_W-1:0] SIG_LO   = 8'h71;
  localparam logic [ADDR_W-1:0] SIG_HI   = 8'h8F;
  localparam logic [ADDR_W-1:0] CTL_BASE = 8'h90;
  localparam logic [ADDR_W-1:0] CTL_HI   = 8'hAF;
  localparam int unsigned INV_BIT  = 9;
  localparam int unsigned FRZ_BIT  = 8;
  localparam logic [BYTE_W-1:0] ALT_MASK = 8'h55;
endpackage

// File: rtl/e1_cas_sig_store.sv
module e1_cas_sig_store
  import e1_cas_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic [TS_W-1:0]   in_ts_i,
  input  logic [FRM_W-1:0]  in_frame_i,
  input  logic              sig_mode_i,
  input  logic [TS_W-1:0]   rd_idx_i,
  output logic [NIB_W-1:0]  rd_nib_o
);
  localparam int unsigned HALF = NUM_TS / 2;

  logic                      cap;
  logic [NIB_W-1:0]          sig_q [NUM_TS];
  logic [NUM_TS*NIB_W-1:0]   sig_flat;

  assign cap = in_valid_i && (in_ts_i == TS_W'(SIG_TS)) && !sig_mode_i
               && (in_frame_i != '0);

  for (genvar g = 0; g < NUM_TS; g++) begin : g_sig
    if (g == 0 || g == HALF) begin : g_none
      assign sig_q[g] = '0;
    end else if (g < HALF) begin : g_hi
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sig_q[g] <= '0;
        else if (cap && in_frame_i == FRM_W'(g)) sig_q[g] <= in_data_i[BYTE_W-1 -: NIB_W];
    end else begin : g_lo
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sig_q[g] <= '0;
        else if (cap && in_frame_i == FRM_W'(g - HALF)) sig_q[g] <= in_data_i[NIB_W-1:0];
    end
    assign sig_flat[g*NIB_W +: NIB_W] = sig_q[g];
  end

  assign rd_nib_o = sig_q[rd_idx_i];

  // R3: no capture while signaling mode is off
  a_r3_mode_off_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_mode_i |=> $stable(sig_flat));
  // R4: frame 0 and non-signaling timeslots never write
  a_r4_no_stray_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_frame_i == '0 || in_ts_i != TS_W'(SIG_TS)) |=> $stable(sig_flat));
endmodule

// File: rtl/e1_cas_ts_ctrl.sv
module e1_cas_ts_ctrl
  import e1_cas_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [NUM_TS-1:0] inv_o,
  output logic [NUM_TS-1:0] frz_o
);
  logic              hit;
  logic [ADDR_W-1:0] off;
  logic [TS_W-1:0]   idx;

  assign hit = (addr_i >= CTL_BASE) && (addr_i <= CTL_HI);
  assign off = addr_i - CTL_BASE;
  assign idx = off[TS_W-1:0];

  for (genvar g = 0; g < NUM_TS; g++) begin : g_ctl
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) begin
        inv_o[g] <= 1'b0;
        frz_o[g] <= 1'b0;
      end else if (we_i && hit && idx == TS_W'(g)) begin
        inv_o[g] <= wdata_i[INV_BIT];
        frz_o[g] <= wdata_i[FRZ_BIT];
      end
  end

  // R7: a write outside the control window leaves all controls alone
  a_r7_ctl_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hit) |=> ($stable(inv_o) && $stable(frz_o)));
endmodule

// File: rtl/e1_cas_dpath.sv
module e1_cas_dpath
  import e1_cas_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic [TS_W-1:0]   in_ts_i,
  input  logic [NUM_TS-1:0] inv_i,
  input  logic [NUM_TS-1:0] frz_i,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_data_o,
  output logic [TS_W-1:0]   out_ts_o
);
  logic [NUM_TS-1:0][BYTE_W-1:0] hold_q;
  logic [BYTE_W-1:0]             mixed;
  logic [BYTE_W-1:0]             nxt;

  assign mixed = in_data_i ^ (inv_i[in_ts_i] ? ALT_MASK : '0);
  assign nxt   = frz_i[in_ts_i] ? hold_q[in_ts_i] : mixed;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_ts_o    <= '0;
      hold_q      <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        out_data_o       <= nxt;
        out_ts_o         <= in_ts_i;
        hold_q[in_ts_i]  <= nxt;
      end
    end

  // R9: inverted timeslots differ from input in exactly the alternate bits
  a_r9_alt_invert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && inv_i[in_ts_i] && !frz_i[in_ts_i])
      |=> ((out_data_o ^ $past(in_data_i)) == ALT_MASK));
  // R8: clear controls pass data unchanged
  a_r8_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !inv_i[in_ts_i] && !frz_i[in_ts_i])
      |=> (out_data_o == $past(in_data_i)));
endmodule

// File: rtl/e1_cas_rx.sv
module e1_cas_rx
  import e1_cas_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  input  logic [4:0]        in_ts_i,
  input  logic [3:0]        in_frame_i,
  input  logic              sig_mode_i,
  input  logic [7:0]        reg_addr_i,
  input  logic              reg_we_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  output logic              out_valid_o,
  output logic [7:0]        out_data_o,
  output logic [4:0]        out_ts_o
);
  logic [NUM_TS-1:0] inv, frz;
  logic [TS_W-1:0]   sig_idx, ctl_idx;
  logic [ADDR_W-1:0] sig_off, ctl_off;
  logic [NIB_W-1:0]  rd_nib;
  logic              sig_hit, ctl_hit;
  logic [REG_W-1:0]  rd_nxt;

  assign sig_hit = (reg_addr_i >= SIG_LO) && (reg_addr_i <= SIG_HI);
  assign ctl_hit = (reg_addr_i >= CTL_BASE) && (reg_addr_i <= CTL_HI);
  assign sig_off = reg_addr_i - SIG_BASE;
  assign ctl_off = reg_addr_i - CTL_BASE;
  assign sig_idx = sig_off[TS_W-1:0];
  assign ctl_idx = ctl_off[TS_W-1:0];

  e1_cas_sig_store u_store (
    .clk_i, .rst_ni, .in_valid_i, .in_data_i, .in_ts_i, .in_frame_i,
    .sig_mode_i, .rd_idx_i(sig_idx), .rd_nib_o(rd_nib)
  );

  e1_cas_ts_ctrl u_ctrl (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .inv_o(inv), .frz_o(frz)
  );

  e1_cas_dpath u_dpath (
    .clk_i, .rst_ni, .in_valid_i, .in_data_i, .in_ts_i,
    .inv_i(inv), .frz_i(frz), .out_valid_o, .out_data_o, .out_ts_o
  );

  always_comb begin
    rd_nxt = '0;
    if (sig_hit) rd_nxt[NIB_W-1:0] = rd_nib;
    else if (ctl_hit) begin
      rd_nxt[INV_BIT] = inv[ctl_idx];
      rd_nxt[FRZ_BIT] = frz[ctl_idx];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) reg_rdata_o <= '0;
    else         reg_rdata_o <= rd_nxt;

  // R8: every accepted byte leaves one cycle later with its timeslot tag
  a_r8_out_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> (out_valid_o && out_ts_o == $past(in_ts_i)));
  // R5: signaling reads carry only a nibble
  a_r5_sig_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_hit |=> (reg_rdata_o[15:4] == '0));
  // R7: control reads carry only the two control bits
  a_r7_ctl_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_hit |=> (reg_rdata_o[15:10] == '0 && reg_rdata_o[7:0] == '0));
endmodule

// File: tb/e1_cas_rx_bench.sv
module e1_cas_rx_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [7:0]  in_data = 0;
  logic [4:0]  in_ts = 0;
  logic [3:0]  in_frame = 0;
  logic        sig_mode = 0;
  logic [7:0]  reg_addr = 0;
  logic        reg_we = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic        out_valid;
  logic [7:0]  out_data;
  logic [4:0]  out_ts;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  e1_cas_rx u_e1_cas_rx (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ts_i(in_ts), .in_frame_i(in_frame), .sig_mode_i(sig_mode),
    .reg_addr_i(reg_addr), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_ts_o(out_ts)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // drive one byte, return output of the following cycle
  task automatic send(input [4:0] ts, input [3:0] fr, input [7:0] d, output [7:0] o);
    in_valid = 1; in_ts = ts; in_frame = fr; in_data = d;
    @(negedge clk);
    in_valid = 0;
    o = out_data;
    chk(out_valid && out_ts == ts, "R8 tag", {out_valid, 3'b0, out_ts}, {1'b1, 3'b0, ts});
  endtask

  task automatic rd(input [7:0] a, output [15:0] v);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic wr(input [7:0] a, input [15:0] v);
    reg_we = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    rd(8'h71, v); chk(v == 0, "R1 sig reg", v, 0);
    rd(8'h8F, v); chk(v == 0, "R1 sig reg hi", v, 0);
    rd(8'h95, v); chk(v == 0, "R1 ctl reg", v, 0);
  endtask

  task automatic t_capture;
    logic [7:0] o; logic [15:0] v;
    for (int f = 1; f < 16; f++) send(5'd16, 4'(f), 8'(f * 17 + 3), o);
    for (int f = 1; f < 16; f++) begin
      logic [7:0] b;
      b = 8'(f * 17 + 3);
      rd(8'(8'h70 + f), v); chk(v == {12'h0, b[7:4]}, "R2 hi nibble", v, b[7:4]);
      rd(8'(8'h80 + f), v); chk(v == {12'h0, b[3:0]}, "R2 lo nibble", v, b[3:0]);
    end
    rd(8'h80, v); chk(v == 0, "R5 offset 0x80", v, 0);
    rd(8'h60, v); chk(v == 0, "R5 unmapped", v, 0);
  endtask

  task automatic t_ignore;
    logic [7:0] o; logic [15:0] v;
    send(5'd16, 4'd0, 8'hFF, o);          // frame 0
    send(5'd15, 4'd2, 8'hFF, o);          // wrong timeslot
    rd(8'h72, v); chk(v == 16'h2, "R4 no stray update", v, 16'h2);
    rd(8'h82, v); chk(v == 16'h5, "R4 no stray update lo", v, 16'h5);
    sig_mode = 1;
    send(5'd16, 4'd2, 8'hAA, o);
    sig_mode = 0;
    rd(8'h72, v); chk(v == 16'h2, "R3 mode off hold", v, 16'h2);
    wr(8'h72, 16'hFFFF);
    rd(8'h72, v); chk(v == 16'h2, "R6 write ignored", v, 16'h2);
  endtask

  task automatic t_invert;
    logic [7:0] o; logic [15:0] v;
    send(5'd3, 4'd1, 8'hC3, o); chk(o == 8'hC3, "R8 passthru", o, 8'hC3);
    wr(8'h93, 16'hFFFF);
    rd(8'h93, v); chk(v == 16'h0200 || v == 16'h0300, "R7 ctl read", v, 16'h0300);
    wr(8'h93, 16'h0200);
    rd(8'h93, v); chk(v == 16'h0200, "R7 inv bit9", v, 16'h0200);
    send(5'd3, 4'd1, 8'hC3, o); chk(o == 8'h96, "R9 invert", o, 8'h96);
    send(5'd4, 4'd1, 8'hC3, o); chk(o == 8'hC3, "R9 other ts", o, 8'hC3);
    wr(8'h93, 16'h0000);
  endtask

  task automatic t_freeze;
    logic [7:0] o; logic [15:0] v;
    send(5'd7, 4'd1, 8'h3C, o);
    wr(8'h97, 16'h0100);
    rd(8'h97, v); chk(v == 16'h0100, "R7 frz bit8", v, 16'h0100);
    send(5'd7, 4'd1, 8'h11, o); chk(o == 8'h3C, "R10 hold", o, 8'h3C);
    send(5'd8, 4'd1, 8'h22, o); chk(o == 8'h22, "R10 other ts", o, 8'h22);
    send(5'd7, 4'd2, 8'h99, o); chk(o == 8'h3C, "R10 hold again", o, 8'h3C);
    wr(8'h97, 16'h0000);
    send(5'd7, 4'd1, 8'h11, o); chk(o == 8'h11, "R10 release", o, 8'h11);
  endtask

  task automatic t_collide;
    logic [15:0] v;
    // control write and same-timeslot byte in one cycle
    reg_we = 1; reg_addr = 8'h95; reg_wdata = 16'h0200;
    in_valid = 1; in_ts = 5'd5; in_frame = 4'd1; in_data = 8'hF0;
    @(negedge clk);
    reg_we = 0; in_valid = 0;
    chk(out_data == 8'hF0, "R11 old ctl", out_data, 8'hF0);
    in_valid = 1; in_data = 8'hF0;
    @(negedge clk);
    in_valid = 0;
    chk(out_data == 8'hA5, "R11 new ctl", out_data, 8'hA5);
    // read and update of the same register in one cycle
    reg_addr = 8'h73;
    in_valid = 1; in_ts = 5'd16; in_frame = 4'd3; in_data = 8'h9C;
    @(negedge clk);
    in_valid = 0;
    chk(reg_rdata == 16'h3, "R11 read old", reg_rdata, 16'h3);
    @(negedge clk);
    chk(reg_rdata == 16'h9, "R11 read new", reg_rdata, 16'h9);
    rd(8'h83, v); chk(v == 16'hC, "R2 lo after collide", v, 16'hC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_capture;
    t_ignore;
    t_invert;
    t_freeze;
    t_collide;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule